// File: doc/BRIEF.md
# Byte-Laned Static RAM Functional Model

This block is a clocked, synthesizable stand-in for a 16-bit-wide asynchronous static RAM with a full depth of 1M words. It is meant to sit behind a memory controller under test, or to serve as on-chip storage in place of the external part. There are no tri-states. The data bus appears as three separate signals: a write-data input, a registered read-data output, and a two-bit lane-enable output that marks which byte lanes would be driven.

Controls are active low: a select, a write strobe, an output gate, and one mask per byte lane. On each rising clock edge the block decodes one of four modes: idle, quiet, fetch or store. In store mode, only the unmasked lanes are written at that edge. In fetch mode, the unmasked lanes are driven one clock later. A parameter sets how many low address bits are backed by storage. Address bits above that count are ignored.

Top module: `lane_sram`

## Requirements
- R1: After synchronous reset, `lane_oe` is 2'b00 and `rd_data` is 16'h0000.
- R2: When `sel_n` is high at an edge (idle mode), `lane_oe` is 2'b00 on the next cycle, and no storage changes, whatever the other inputs are.
- R3: When `sel_n`=0, `wr_n`=1 and `gate_n`=1 at an edge (quiet mode), `lane_oe` is 2'b00 on the next cycle and storage is unchanged.
- R4: When `sel_n`=0, `wr_n`=1 and `gate_n`=0 at an edge (fetch mode), on the next cycle `lane_oe[0]` equals the inverse of `mask_n[0]` and `lane_oe[1]` equals the inverse of `mask_n[1]`. Each enabled lane carries the stored byte at that address: lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R5: In fetch mode, a lane whose mask is high shows 8'h00 on `rd_data`.
- R6: When `sel_n`=0 and `wr_n`=0 at an edge (store mode), `gate_n` is ignored and `lane_oe` is 2'b00 on the next cycle.
- R7: In store mode, lane 0 of the word is written from `wr_data[7:0]` only if `mask_n[0]`=0, and lane 1 from `wr_data[15:8]` only if `mask_n[1]`=0. A masked lane keeps its old value.
- R8: A store with both masks high changes no storage.
- R9: Only the low `ADDR_KEEP` address bits select a word. Addresses that differ only above that bit reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| addr | input | 20 | Word address |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| gate_n | input | 1 | Active-low output gate |
| mask_n | input | 2 | Active-low lane masks; bit 0 is the low byte, bit 1 is the high byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data; disabled lanes read zero |
| lane_oe | output | 2 | Registered per-lane drive enables |

## Verification
Embedded properties check, on every cycle, the link between the mode decoded at one edge and the lane enables and zeroed lanes seen one cycle later. They show that no lane drives after an idle, quiet or store cycle, and that the drive enables follow the inverse of the masks after a fetch. Whether the right bytes were kept, merged or left alone can only be shown by the bench's scenarios. These scenarios cover partial-lane stores, stores with both lanes masked, stores made while idle or quiet, and address aliasing above the kept bits. Each of them writes a word and reads it back later through the normal interface.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
    localparam int ADDR_W = 20;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_QUIET = 2'd1,
        MODE_FETCH = 2'd2,
        MODE_STORE = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic [LANES-1:0]   lane_en;
    } access_t;

    function automatic mode_e decode_mode(input logic sel_n, input logic wr_n,
                                          input logic gate_n);
        if (sel_n)       return MODE_IDLE;
        else if (!wr_n)  return MODE_STORE;
        else if (!gate_n) return MODE_FETCH;
        else             return MODE_QUIET;
    endfunction
endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
    import lane_sram_pkg::*;
(
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic             gate_n,
    input  logic [LANES-1:0] mask_n,
    output access_t          acc
);
    always_comb begin
        acc.mode    = decode_mode(sel_n, wr_n, gate_n);
        acc.lane_en = ~mask_n;
    end
endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
    parameter int AW = 10,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] idx,
    input  logic          we,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);
    localparam int DEPTH = 1 << AW;
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= din;
    end

    assign dout = cells[idx];
endmodule

// File: rtl/lane_sram.sv
module lane_sram
    import lane_sram_pkg::*;
#(
    parameter int ADDR_KEEP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              gate_n,
    input  logic [LANES-1:0]  mask_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  lane_oe
);
    localparam int KEEP = (ADDR_KEEP > ADDR_W) ? ADDR_W : ADDR_KEEP;

    access_t           acc;
    logic [KEEP-1:0]   idx;
    logic [DATA_W-1:0] word;

    lane_sram_decode u_dec (
        .sel_n (sel_n), .wr_n (wr_n), .gate_n (gate_n),
        .mask_n(mask_n), .acc (acc)
    );

    assign idx = addr[KEEP-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_we;
        assign lane_we = (acc.mode == MODE_STORE) && acc.lane_en[g];
        lane_sram_bank #(.AW(KEEP), .W(LANE_W)) u_bank (
            .clk (clk),
            .idx (idx),
            .we  (lane_we),
            .din (wr_data[g*LANE_W +: LANE_W]),
            .dout(word[g*LANE_W +: LANE_W])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_oe[g]                  <= 1'b0;
                rd_data[g*LANE_W +: LANE_W] <= '0;
            end else if (acc.mode == MODE_FETCH && acc.lane_en[g]) begin
                lane_oe[g]                  <= 1'b1;
                rd_data[g*LANE_W +: LANE_W] <= word[g*LANE_W +: LANE_W];
            end else begin
                lane_oe[g]                  <= 1'b0;
                rd_data[g*LANE_W +: LANE_W] <= '0;
            end
        end

        // R5
        lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !lane_oe[g] |-> rd_data[g*LANE_W +: LANE_W] == '0);
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> lane_oe == '0);
    // R3
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && wr_n && gate_n) |=> lane_oe == '0);
    // R6
    store_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n) |=> lane_oe == '0);
    // R4
    fetch_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && wr_n && !gate_n) |=> lane_oe == ~$past(mask_n));
    // R1
    reset_chk: assert property (@(posedge clk)
        rst |=> (lane_oe == '0 && rd_data == '0));
endmodule

// File: tb/lane_sram_bench.sv
module lane_sram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int KEEP = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic [19:0] addr = '0;
    logic        sel_n = 1, wr_n = 1, gate_n = 1;
    logic [1:0]  mask_n = 2'b11;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  lane_oe;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_sram #(.ADDR_KEEP(KEEP)) u_lane_sram (
        .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
        .gate_n(gate_n), .mask_n(mask_n), .wr_data(wr_data),
        .rd_data(rd_data), .lane_oe(lane_oe)
    );

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply inputs on the falling edge, clock once, sample next falling edge
    task automatic cyc(logic s, logic w, logic g, logic [1:0] m,
                       logic [19:0] a, logic [15:0] d);
        sel_n = s; wr_n = w; gate_n = g; mask_n = m; addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        sel_n = 1; wr_n = 1; gate_n = 1; mask_n = 2'b11;
    endtask

    task automatic rd(logic [19:0] a, logic [1:0] m, string req,
                      logic [1:0] exp_oe, logic [15:0] exp_d);
        cyc(0, 1, 0, m, a, '0);
        check(req, {lane_oe, rd_data}, {exp_oe, exp_d});
    endtask

    task automatic t_reset();
        check("R1", {lane_oe, rd_data}, 18'h0);
    endtask

    task automatic t_full_rw();
        cyc(0, 0, 1, 2'b00, 20'h00012, 16'hA55A);
        check("R6", {16'h0, lane_oe}, 18'h0);
        rd(20'h00012, 2'b00, "R4", 2'b11, 16'hA55A);
        rd(20'h00012, 2'b10, "R5", 2'b01, 16'h005A);
        rd(20'h00012, 2'b01, "R5", 2'b10, 16'hA500);
        rd(20'h00012, 2'b11, "R5", 2'b00, 16'h0000);
    endtask

    task automatic t_lane_write();
        cyc(0, 0, 0, 2'b00, 20'h00020, 16'h1122);
        check("R6", {16'h0, lane_oe}, 18'h0); // gate low ignored
        cyc(0, 0, 1, 2'b10, 20'h00020, 16'hFFEE);
        rd(20'h00020, 2'b00, "R7", 2'b11, 16'h11EE);
        cyc(0, 0, 1, 2'b01, 20'h00020, 16'h77DD);
        rd(20'h00020, 2'b00, "R7", 2'b11, 16'h77EE);
    endtask

    task automatic t_no_write();
        cyc(0, 0, 1, 2'b11, 20'h00020, 16'h0000);
        rd(20'h00020, 2'b00, "R8", 2'b11, 16'h77EE);
        cyc(1, 0, 0, 2'b00, 20'h00020, 16'h0000);
        check("R2", {16'h0, lane_oe}, 18'h0);
        rd(20'h00020, 2'b00, "R2", 2'b11, 16'h77EE);
        cyc(0, 1, 1, 2'b00, 20'h00020, 16'h0000);
        check("R3", {16'h0, lane_oe}, 18'h0);
        rd(20'h00020, 2'b00, "R3", 2'b11, 16'h77EE);
    endtask

    task automatic t_alias();
        cyc(0, 0, 1, 2'b00, 20'hABC33, 16'hBEEF);
        rd(20'h00033, 2'b00, "R9", 2'b11, 16'hBEEF);
        cyc(0, 0, 1, 2'b00, 20'h00034, 16'h4321);
        rd(20'hFFF34, 2'b00, "R9", 2'b11, 16'h4321);
        rd(20'h00033, 2'b00, "R9", 2'b11, 16'hBEEF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 0;
        t_full_rw();
        t_lane_write();
        t_no_write();
        t_alias();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule